// File: doc/BRIEF.md
# Not-Recently-Used Way Replacement Controller

This block chooses which way of a set-associative cache set to evict, and produces the updates for a per-set state memory that the block does not own. Each set keeps one reference bit per way. A set bit means the way was used recently. A victim is picked only from the ways whose bit is clear. When every way in a set has been used, the whole set is reset so that all ways become candidates again.

The state memory has two restrictions. During the victim lookup it can only be read, and during the later update it can only be written. The cache reads a set's bits and presents them with a lookup request. The block returns the victim one cycle later. It also keeps those bits, reduced to an "all used" flag tagged with the set index, in a holding register until the matching fill arrives. The fill update can then widen its write mask and clear the other ways without reading the memory again. Hit updates come without any lookup. They set only the hit way's bit, and leave any clearing to the next lookup of that set.

Top module: `nru_repl_ctrl`

## Requirements
- R1: After reset, `vic_valid` and `wr_en` are 0 until a request arrives.
- R2: One cycle after `dec_valid`, `vic_valid` is 1 and `vic_way` is the lowest-numbered way whose bit in `dec_bits` is 0. Bit i of every way vector stands for way i, and 1 means recently used.
- R3: If all bits of `dec_bits` are 1, the victim one cycle later is way 0.
- R4: One cycle after a fill (`enc_valid` with `enc_fill`=1) whose set matches a held lookup that was not all used, `wr_data` and `wr_mask` both equal the one-hot vector of `enc_way`.
- R5: One cycle after a fill whose set matches a held lookup that was all used, `wr_data` is the one-hot vector of `enc_way` and `wr_mask` is all ones, which clears the other ways.
- R6: A hit (`enc_fill`=0) writes the one-hot vector of `enc_way` under a one-hot mask, whatever is held. The hit leaves the held lookup in place for a later fill.
- R7: A fill for a set other than the held one, or with nothing held, writes the one-hot vector under a one-hot mask.
- R8: A fill consumes the held lookup. A second fill to the same set with no new lookup in between uses a one-hot mask.
- R9: `wr_en` is 1 exactly in the cycle after each `enc_valid`, with `wr_set` equal to that request's `enc_set`.
- R10: When a lookup and a fill arrive in the same cycle, the fill uses the lookup held before that cycle, and the new lookup becomes the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Victim lookup request |
| dec_set | input | SET_W | Set index of the lookup |
| dec_bits | input | WAYS | Reference bits read from the state memory for `dec_set` |
| vic_valid | output | 1 | Victim result valid |
| vic_way | output | WAY_W | Chosen victim way |
| enc_valid | input | 1 | Update request |
| enc_fill | input | 1 | 1 for a fill, 0 for a hit |
| enc_set | input | SET_W | Set index of the update |
| enc_way | input | WAY_W | Way that was filled or hit |
| wr_en | output | 1 | State memory write enable |
| wr_set | output | SET_W | State memory write index |
| wr_data | output | WAYS | Bits to write |
| wr_mask | output | WAYS | Per-way write enable |

## Verification
Both results are registered once. The victim appears in the cycle after `dec_valid`, and the write outputs appear in the cycle after `enc_valid`. The holding register is updated on the same edge, so a lookup affects fills from the next cycle onward. The bench drives each request on a falling edge and samples 1 ns after the following rising edge, which is exactly when the result is due. Before the next request, it applies every observed write to its own copy of the state memory. That copy is compared with an independent reference model across directed cases and a random run of lookups, hits and fills over a few colliding sets.

// File: rtl/nru_pkg.sv
// Package: shared encodings for the NRU replacement controller.
// Assumes: nothing beyond IEEE 1800-2017.
package nru_pkg;
    // Shape of the write that an update produces.
    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_ONEHOT  = 2'd1,
        WR_RESTART = 2'd2
    } wr_form_e;

    // Held lookup: valid flag, all-used flag; the set tag is kept beside it.
    typedef struct packed {
        logic valid;
        logic all_used;
    } hold_flags_t;
endpackage

// File: rtl/nru_victim_pick.sv
// Module: combinational victim selection.
// Finds the lowest-numbered way whose reference bit is clear and flags
// the case where every bit is set (victim then defaults to way 0).
// Assumes: WAYS >= 2.
module nru_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  bits,
    output logic [WAY_W-1:0] way,
    output logic             all_used
);
    // Scan from the top way down so the lowest clear way wins.
    always_comb begin
        way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!bits[i]) way = WAY_W'(i);
        end
        all_used = &bits;
    end
endmodule

// File: rtl/nru_hold_reg.sv
// Module: holding register carrying lookup state to the later fill.
// Captures the set index and all-used flag on a lookup; a fill clears it.
// A lookup in the same cycle as a fill wins, so the new lookup is kept.
// Assumes: synchronous active-low reset.
module nru_hold_reg #(
    parameter int SET_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [SET_W-1:0]     capture_set,
    input  logic                 capture_all,
    input  logic                 consume,
    output nru_pkg::hold_flags_t flags,
    output logic [SET_W-1:0]     held_set
);
    // Update the held lookup: capture beats consume, consume drops validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags    <= '0;
            held_set <= '0;
        end else if (capture) begin
            flags.valid    <= 1'b1;
            flags.all_used <= capture_all;
            held_set       <= capture_set;
        end else if (consume) begin
            flags.valid    <= 1'b0;
            flags.all_used <= 1'b0;
        end
    end
endmodule

// File: rtl/nru_encode_gen.sv
// Module: update write generator.
// Turns a hit or fill into a masked state-memory write, registered once.
// A fill matching an all-used held lookup writes with a full mask; every
// other update writes a one-hot mask on its own way.
// Assumes: WAYS >= 2; hold inputs reflect state before this cycle's edge.
module nru_encode_gen #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int SET_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enc_valid,
    input  logic                 enc_fill,
    input  logic [SET_W-1:0]     enc_set,
    input  logic [WAY_W-1:0]     enc_way,
    input  nru_pkg::hold_flags_t flags,
    input  logic [SET_W-1:0]     held_set,
    output logic                 wr_en,
    output logic [SET_W-1:0]     wr_set,
    output logic [WAYS-1:0]      wr_data,
    output logic [WAYS-1:0]      wr_mask
);
    import nru_pkg::*;

    localparam logic [WAYS-1:0] ONE = {{(WAYS-1){1'b0}}, 1'b1};

    wr_form_e        form;
    logic [WAYS-1:0] way_oh;

    // Classify the incoming update and build its one-hot way vector.
    always_comb begin
        way_oh = ONE << enc_way;
        if (!enc_valid)
            form = WR_NONE;
        else if (enc_fill && flags.valid && flags.all_used && held_set == enc_set)
            form = WR_RESTART;
        else
            form = WR_ONEHOT;
    end

    // Register the write towards the state memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_set  <= '0;
            wr_data <= '0;
            wr_mask <= '0;
        end else begin
            wr_en <= (form != WR_NONE);
            if (form != WR_NONE) begin
                wr_set  <= enc_set;
                wr_data <= way_oh;
                wr_mask <= (form == WR_RESTART) ? '1 : way_oh;
            end
        end
    end
endmodule

// File: rtl/nru_repl_ctrl.sv
// Module: top of the NRU replacement controller.
// Lookups return a registered victim one cycle later and record the set's
// all-used state; updates produce a registered masked write one cycle later.
// Assumes: the state memory is external and read by the caller for dec_set.
module nru_repl_ctrl #(
    parameter int WAYS  = 4,
    parameter int SETS  = 64,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [SET_W-1:0] dec_set,
    input  logic [WAYS-1:0]  dec_bits,
    output logic             vic_valid,
    output logic [WAY_W-1:0] vic_way,
    input  logic             enc_valid,
    input  logic             enc_fill,
    input  logic [SET_W-1:0] enc_set,
    input  logic [WAY_W-1:0] enc_way,
    output logic             wr_en,
    output logic [SET_W-1:0] wr_set,
    output logic [WAYS-1:0]  wr_data,
    output logic [WAYS-1:0]  wr_mask
);
    logic [WAY_W-1:0]     pick_way;
    logic                 pick_all;
    nru_pkg::hold_flags_t flags;
    logic [SET_W-1:0]     held_set;

    nru_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .bits     (dec_bits),
        .way      (pick_way),
        .all_used (pick_all)
    );

    nru_hold_reg #(.SET_W(SET_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (dec_valid),
        .capture_set (dec_set),
        .capture_all (pick_all),
        .consume     (enc_valid && enc_fill),
        .flags       (flags),
        .held_set    (held_set)
    );

    nru_encode_gen #(.WAYS(WAYS), .WAY_W(WAY_W), .SET_W(SET_W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .enc_valid (enc_valid),
        .enc_fill  (enc_fill),
        .enc_set   (enc_set),
        .enc_way   (enc_way),
        .flags     (flags),
        .held_set  (held_set),
        .wr_en     (wr_en),
        .wr_set    (wr_set),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask)
    );

    // Register the victim result of each lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid <= 1'b0;
            vic_way   <= '0;
        end else begin
            vic_valid <= dec_valid;
            if (dec_valid) vic_way <= pick_way;
        end
    end
endmodule

// File: rtl/nru_repl_chk.sv
// Module: property checker for nru_repl_ctrl, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module nru_repl_chk #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int SET_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic [WAYS-1:0]  dec_bits,
    input logic             vic_valid,
    input logic [WAY_W-1:0] vic_way,
    input logic             enc_valid,
    input logic             enc_fill,
    input logic [SET_W-1:0] enc_set,
    input logic             wr_en,
    input logic [SET_W-1:0] wr_set,
    input logic [WAYS-1:0]  wr_data,
    input logic [WAYS-1:0]  wr_mask
);
    localparam logic [WAYS-1:0] ONE = {{(WAYS-1){1'b0}}, 1'b1};

    AST_VIC_FOLLOWS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> vic_valid); // R2
    AST_VIC_IS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !(&dec_bits)) |=> ((($past(dec_bits) >> vic_way) & ONE) == '0)); // R2
    AST_FULL_PICKS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&dec_bits)) |=> (vic_way == '0)); // R3
    AST_WR_FOLLOWS_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |=> (wr_en && wr_set == $past(enc_set))); // R9
    AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid |=> !wr_en); // R9
    AST_DATA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_data) == 1 && (wr_data & ~wr_mask) == '0)); // R4
    AST_HIT_NARROW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid && !enc_fill) |=> (wr_mask == wr_data)); // R6
endmodule

bind nru_repl_ctrl nru_repl_chk #(.WAYS(WAYS), .WAY_W(WAY_W), .SET_W(SET_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_bits  (dec_bits),
    .vic_valid (vic_valid),
    .vic_way   (vic_way),
    .enc_valid (enc_valid),
    .enc_fill  (enc_fill),
    .enc_set   (enc_set),
    .wr_en     (wr_en),
    .wr_set    (wr_set),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask)
);

// File: tb/sim_nru_repl_ctrl.sv
// Bench: directed scenarios plus a random run against a reference model.
module sim_nru_repl_ctrl;
    localparam int WAYS = 4;
    localparam int SETS = 64;
    localparam int WAY_W = 2;
    localparam int SET_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0, enc_valid = 1'b0, enc_fill = 1'b0;
    logic [SET_W-1:0] dec_set = '0, enc_set = '0;
    logic [WAYS-1:0]  dec_bits = '0;
    logic [WAY_W-1:0] enc_way = '0;
    logic vic_valid, wr_en;
    logic [WAY_W-1:0] vic_way;
    logic [SET_W-1:0] wr_set;
    logic [WAYS-1:0]  wr_data, wr_mask;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic [WAYS-1:0] mem [SETS];
    logic [WAYS-1:0] ref_mem [SETS];
    logic            ref_hv, ref_ha;
    logic [SET_W-1:0] ref_hs;

    always #2 clk = ~clk;

    nru_repl_ctrl #(.WAYS(WAYS), .SETS(SETS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_set(dec_set), .dec_bits(dec_bits),
        .vic_valid(vic_valid), .vic_way(vic_way),
        .enc_valid(enc_valid), .enc_fill(enc_fill), .enc_set(enc_set), .enc_way(enc_way),
        .wr_en(wr_en), .wr_set(wr_set), .wr_data(wr_data), .wr_mask(wr_mask)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // One cycle: drive on the falling edge, sample just after the rising edge,
    // then apply any observed write to the bench's copy of the state memory.
    task automatic cyc(input logic dv, input logic [SET_W-1:0] ds, input logic [WAYS-1:0] db,
                       input logic ev, input logic ef, input logic [SET_W-1:0] es,
                       input logic [WAY_W-1:0] ew);
        @(negedge clk);
        dec_valid = dv; dec_set = ds; dec_bits = db;
        enc_valid = ev; enc_fill = ef; enc_set = es; enc_way = ew;
        @(posedge clk); #1;
        if (wr_en) mem[wr_set] = (mem[wr_set] & ~wr_mask) | (wr_data & wr_mask);
        @(negedge clk);
        dec_valid = 0; enc_valid = 0;
    endtask

    task automatic dec(input logic [SET_W-1:0] s, input logic [WAYS-1:0] b, input int exp_way, string req);
        cyc(1, s, b, 0, 0, '0, '0);
        check({req, " victim valid"}, 32'(vic_valid), 1);
        check({req, " victim way"}, 32'(vic_way), 32'(exp_way));
    endtask

    task automatic enc(input logic f, input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w,
                       input logic [WAYS-1:0] exp_mask, string req);
        cyc(0, '0, '0, 1, f, s, w);
        check({req, " wr_en"}, 32'(wr_en), 1);
        check({req, " wr_set"}, 32'(wr_set), 32'(s));
        check({req, " wr_data"}, 32'(wr_data), 32'(4'b0001 << w));
        check({req, " wr_mask"}, 32'(wr_mask), 32'(exp_mask));
    endtask

    task automatic t_reset();
        check("R1 vic_valid after reset", 32'(vic_valid), 0);
        check("R1 wr_en after reset", 32'(wr_en), 0);
    endtask

    task automatic t_lowest_clear();
        dec(1, 4'b0000, 0, "R2");
        dec(1, 4'b0001, 1, "R2");
        dec(1, 4'b0101, 1, "R2");
        dec(1, 4'b0111, 3, "R2");
        dec(1, 4'b1011, 2, "R2");
    endtask

    task automatic t_all_used();
        dec(2, 4'b1111, 0, "R3");
    endtask

    task automatic t_fill_partial();
        dec(5, 4'b0011, 2, "R4");
        enc(1, 5, 2, 4'b0100, "R4");
    endtask

    task automatic t_fill_restart();
        dec(6, 4'b1111, 0, "R5");
        enc(1, 6, 0, 4'b1111, "R5");
    endtask

    task automatic t_hit();
        dec(7, 4'b1111, 0, "R6");
        enc(0, 7, 3, 4'b1000, "R6 hit");
        enc(1, 7, 0, 4'b1111, "R6 hold kept");
    endtask

    task automatic t_other_set();
        dec(8, 4'b1111, 0, "R7");
        enc(1, 9, 1, 4'b0010, "R7 other set");
    endtask

    task automatic t_consume();
        dec(10, 4'b1111, 0, "R8");
        enc(1, 10, 0, 4'b1111, "R8 first");
        enc(1, 10, 0, 4'b0001, "R8 second");
    endtask

    task automatic t_quiet();
        cyc(0, '0, '0, 0, 0, '0, '0);
        check("R9 no write when idle", 32'(wr_en), 0);
    endtask

    task automatic t_same_cycle();
        dec(11, 4'b1111, 0, "R10");
        cyc(1, 12, 4'b1111, 1, 1, 11, 0);
        check("R10 fill uses prior hold", 32'(wr_mask), 32'(4'b1111));
        check("R10 victim of new lookup", 32'(vic_way), 0);
        enc(1, 12, 0, 4'b1111, "R10 new hold");
    endtask

    task automatic ref_update(input logic f, input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w);
        logic [WAYS-1:0] oh;
        oh = 4'b0001 << w;
        if (f && ref_hv && ref_ha && ref_hs == s) ref_mem[s] = oh;
        else ref_mem[s] = ref_mem[s] | oh;
        if (f) ref_hv = 0;
    endtask

    task automatic t_random();
        for (int s = 0; s < SETS; s++) begin mem[s] = '0; ref_mem[s] = '0; end
        ref_hv = 0; ref_ha = 0; ref_hs = '0;
        for (int k = 0; k < 300; k++) begin
            logic [SET_W-1:0] s, hs;
            logic [WAY_W-1:0] hw;
            int ev;
            s = SET_W'($urandom_range(0, 3));
            ev = 0;
            for (int i = WAYS - 1; i >= 0; i--) if (!ref_mem[s][i]) ev = i;
            cyc(1, s, mem[s], 0, 0, '0, '0);
            check("R2 random victim", 32'(vic_way), 32'(ev));
            ref_hv = 1; ref_ha = &ref_mem[s]; ref_hs = s;
            if ($urandom_range(0, 1) == 1) begin
                hs = SET_W'($urandom_range(0, 3));
                hw = WAY_W'($urandom_range(0, WAYS - 1));
                cyc(0, '0, '0, 1, 0, hs, hw);
                ref_update(0, hs, hw);
                check("R6 random hit state", 32'(mem[hs]), 32'(ref_mem[hs]));
            end
            cyc(0, '0, '0, 1, 1, s, WAY_W'(ev));
            ref_update(1, s, WAY_W'(ev));
            check("R5 random fill state", 32'(mem[s]), 32'(ref_mem[s]));
        end
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) mem[s] = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_lowest_clear();
        t_all_used();
        t_fill_partial();
        t_fill_restart();
        t_hit();
        t_other_set();
        t_consume();
        t_quiet();
        t_same_cycle();
        t_random();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule